// File: doc/BRIEF.md
# DMA Channel Grant Arbiter

This block decides which DMA channel may use the shared memory engine next. It serves a set of injection channels plus two extraction channels. The default build has eight channels: indices 0 to 5 are injection channels and indices 6 and 7 are extraction channels. Every channel belongs to one of two CPU ports. The extraction channels have a fixed port. Each injection channel picks its port through its own configuration bit.

Arbitration works on two levels. Inside a port, the channels are in fixed priority. Between the two ports, grants alternate so that both ports get a fair share. A channel that holds the grant keeps it through a whole frame. The arbiter therefore changes ownership only between frames.

The engine accepts a beat in any cycle where the granted channel is requesting and is activated. The start-of-frame and end-of-frame markers of that channel qualify the beat.

Top module: `dma_chan_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `gnt` is all zero and `gnt_port` is 0.
- R2: `gnt` is one-hot or all zero. It is a register: a new grant appears on the clock edge that follows the cycle in which the request was seen. A new grant only goes to a channel that was requesting and activated in that cycle.
- R3: Bit i of `inj_port` places injection channel i on port 0 (bit value 0) or port 1 (bit value 1). Channel index N_INJ always serves port 0 and channel index N_INJ+1 always serves port 1. `gnt_port` shows the port of the granted channel, and 0 when nothing is granted.
- R4: Within a port, a requesting extraction channel wins over every injection channel.
- R5: Among injection channels on the same port, the higher channel index wins.
- R6: When both ports have candidates at a decision, the port that was not given the latest new grant wins. After reset, port 0 is preferred.
- R7: A beat is accepted when `gnt[i] & ch_req[i] & ch_act[i]`. Once a start-of-frame beat is accepted, the owner keeps the grant until its end-of-frame beat is accepted. This holds even if a higher-priority channel requests, and even while the owner lowers its request in the middle of the frame.
- R8: A channel whose `ch_act` bit is 0 is never granted. If the owner is deactivated, it loses the grant at the next edge, even in the middle of a frame.
- R9: Before its first start-of-frame beat, the owner keeps the grant while it requests. Higher-priority requests do not take it away. The owner releases the grant when it drops its request.
- R10: A frame may be a single beat, with both markers set. A channel whose frame ends in a cycle is not a candidate in that same decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_req | input | N_INJ+2 | Per-channel request / beat valid |
| ch_act | input | N_INJ+2 | Per-channel activation |
| ch_sof | input | N_INJ+2 | Start-of-frame marker of the current beat |
| ch_eof | input | N_INJ+2 | End-of-frame marker of the current beat |
| inj_port | input | N_INJ | Port select per injection channel |
| gnt | output | N_INJ+2 | Registered one-hot grant |
| gnt_port | output | 1 | Port served by the current grant |

## Verification
The bench uses the default N_INJ of 6, which gives the full eight-channel arrangement. This reaches both fixed extraction channels and injection channels mapped to either port. The bench drives directed cycle sequences and checks each one against the expected grant. The sequences cover:
- a preemption attempt during a locked frame,
- a stall in the middle of a frame,
- a deactivation in the middle of a frame,
- port alternation when both ports are waiting,
- the reset preference for port 0,
- a reprogrammed port-select bit.

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int N_INJ = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_INJ+1:0]   ch_req,
  input  logic [N_INJ+1:0]   ch_act,
  input  logic [N_INJ+1:0]   ch_sof,
  input  logic [N_INJ+1:0]   ch_eof,
  input  logic [N_INJ-1:0]   inj_port,
  output logic [N_INJ+1:0]   gnt,
  output logic               gnt_port
);
  localparam int NCH = N_INJ + 2;

  logic [NCH-1:0] ch_port, beat, cand, pick0, pick1, nxt;
  logic locked_q, last_q;
  logic sof_b, eof_b, own_act, own_req, in_frame, hold;
  logic has0, has1, sel_port;

  for (genvar i = 0; i < NCH; i++) begin : g_map
    if (i < N_INJ) begin : g_inj
      assign ch_port[i] = inj_port[i];
    end else begin : g_xtr
      assign ch_port[i] = (i == NCH - 1);
    end
  end

  assign beat     = gnt & ch_req & ch_act;
  assign sof_b    = |(beat & ch_sof);
  assign eof_b    = |(beat & ch_eof);
  assign own_act  = |(gnt & ch_act);
  assign own_req  = |(gnt & ch_req);
  assign in_frame = locked_q | sof_b;
  assign hold     = own_act & ~eof_b & (in_frame | own_req);
  assign cand     = ch_req & ch_act & ~gnt;

  always_comb begin
    pick0 = '0;
    pick1 = '0;
    for (int i = 0; i < NCH; i++) begin
      if (cand[i]) begin
        if (ch_port[i]) begin
          pick1    = '0;
          pick1[i] = 1'b1;
        end else begin
          pick0    = '0;
          pick0[i] = 1'b1;
        end
      end
    end
  end

  assign has0     = |pick0;
  assign has1     = |pick1;
  assign sel_port = (has0 & has1) ? ~last_q : has1;
  assign nxt      = hold ? gnt : (sel_port ? pick1 : pick0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt      <= '0;
      gnt_port <= 1'b0;
      locked_q <= 1'b0;
      last_q   <= 1'b1;
    end else begin
      gnt      <= nxt;
      gnt_port <= hold ? gnt_port : sel_port;
      locked_q <= hold & in_frame;
      if (!hold && (has0 || has1)) last_q <= sel_port;
    end
  end
endmodule

module dma_chan_arbiter_chk #(
  parameter int N_INJ = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_INJ+1:0] ch_req,
  input logic [N_INJ+1:0] ch_act,
  input logic [N_INJ+1:0] ch_sof,
  input logic [N_INJ+1:0] ch_eof,
  input logic [N_INJ+1:0] gnt,
  input logic             gnt_port
);
  localparam int NCH = N_INJ + 2;

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_new_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt && gnt != $past(gnt)) |-> |($past(ch_req & ch_act) & gnt));

  p_xtr0_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[NCH-2] |-> !gnt_port);

  p_xtr1_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[NCH-1] |-> gnt_port);

  p_frame_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt & ch_req & ch_act & ch_sof) && !(|(gnt & ch_req & ch_act & ch_eof)))
      |=> gnt == $past(gnt));

  p_deact_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt & ~ch_act)) |=> ((gnt & $past(gnt)) == '0));
endmodule

bind dma_chan_arbiter dma_chan_arbiter_chk #(.N_INJ(N_INJ)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_act(ch_act),
  .ch_sof(ch_sof), .ch_eof(ch_eof), .gnt(gnt), .gnt_port(gnt_port)
);

// File: tb/sim_dma_chan_arbiter.sv
module sim_dma_chan_arbiter;
  localparam int N_INJ = 6;
  localparam int NCH   = N_INJ + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] ch_req = '0, ch_act = '0, ch_sof = '0, ch_eof = '0;
  logic [N_INJ-1:0] inj_port = '0;
  logic [NCH-1:0] gnt;
  logic gnt_port;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [NCH-1:0] g;
    logic           p;
    string          tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  dma_chan_arbiter #(.N_INJ(N_INJ)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_act(ch_act),
    .ch_sof(ch_sof), .ch_eof(ch_eof), .inj_port(inj_port),
    .gnt(gnt), .gnt_port(gnt_port)
  );

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (gnt !== e.g || gnt_port !== e.p) begin
        fails++;
        $display("FAIL %s: gnt=%h port=%0d expected gnt=%h port=%0d",
                 e.tag, gnt, gnt_port, e.g, e.p);
      end
    end
  end

  task automatic cyc(input logic [NCH-1:0] r, a, s, e,
                     input logic [NCH-1:0] eg, input logic ep, input string tag);
    exp_t x;
    ch_req = r; ch_act = a; ch_sof = s; ch_eof = e;
    @(posedge clk);
    x.g = eg; x.p = ep; x.tag = tag;
    exp_q.push_back(x);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (gnt !== '0 || gnt_port !== 1'b0) begin
      fails++;
      $display("FAIL R1: gnt=%h port=%0d expected gnt=00 port=0", gnt, gnt_port);
    end
    rst_n = 1'b1;
    cyc('0, 8'hFF, '0, '0, 8'h00, 1'b0, "R1 idle after reset");
    // R6 reset preference: both ports waiting
    cyc(8'hC0, 8'hFF, '0, '0, 8'h40, 1'b0, "R6 reset prefers port 0");
    cyc(8'h00, 8'hFF, '0, '0, 8'h00, 1'b0, "R9 release on dropped request");
    // R5 / R10 injection order and single-beat frames
    cyc(8'h0A, 8'hFF, '0, '0, 8'h08, 1'b0, "R5 higher injection wins");
    cyc(8'h0A, 8'hFF, 8'h08, 8'h08, 8'h02, 1'b0, "R10 single beat, next channel");
    cyc(8'h02, 8'hFF, 8'h02, 8'h02, 8'h00, 1'b0, "R10 finisher not re-granted");
    // R4 / R7 / R6
    cyc(8'h44, 8'hFF, '0, '0, 8'h40, 1'b0, "R4 extraction beats injection");
    cyc(8'h44, 8'hFF, 8'h40, '0, 8'h40, 1'b0, "R7 frame started");
    cyc(8'hC4, 8'hFF, '0, '0, 8'h40, 1'b0, "R7 no preemption mid-frame");
    cyc(8'h84, 8'hFF, '0, '0, 8'h40, 1'b0, "R7 stall keeps grant");
    cyc(8'hC4, 8'hFF, '0, 8'h40, 8'h80, 1'b1, "R6 other port after frame");
    cyc(8'hC4, 8'hFF, 8'h80, 8'h80, 8'h40, 1'b0, "R4 extraction first on port 0");
    cyc(8'h44, 8'hFF, 8'h40, 8'h40, 8'h04, 1'b0, "R5 remaining injection");
    cyc(8'h04, 8'hFF, 8'h04, 8'h04, 8'h00, 1'b0, "R10 idle after frame");
    // R3 port select
    inj_port = 6'b000010;
    cyc(8'h03, 8'hFF, '0, '0, 8'h02, 1'b1, "R3 channel 1 mapped to port 1");
    cyc(8'h03, 8'hFF, 8'h02, 8'h02, 8'h01, 1'b0, "R3 channel 0 on port 0");
    cyc(8'h01, 8'hFF, 8'h01, 8'h01, 8'h00, 1'b0, "R3 idle");
    inj_port = '0;
    // R8 deactivation
    cyc(8'h20, 8'hFF, '0, '0, 8'h20, 1'b0, "R8 grant channel 5");
    cyc(8'h20, 8'hFF, 8'h20, '0, 8'h20, 1'b0, "R7 channel 5 in frame");
    cyc(8'h30, 8'hDF, '0, '0, 8'h10, 1'b0, "R8 deactivated owner released");
    cyc(8'h30, 8'hFF, 8'h10, 8'h10, 8'h20, 1'b0, "R8 reactivated channel granted");
    cyc(8'h20, 8'hFF, 8'h20, 8'h20, 8'h00, 1'b0, "R10 idle");
    cyc(8'h80, 8'h7F, '0, '0, 8'h00, 1'b0, "R8 inactive request ignored");
    cyc(8'h80, 8'h7F, '0, '0, 8'h00, 1'b0, "R8 inactive stays ignored");
    // R9 no preemption before frame start
    cyc(8'h01, 8'hFF, '0, '0, 8'h01, 1'b0, "R2 grant one cycle later");
    cyc(8'h09, 8'hFF, '0, '0, 8'h01, 1'b0, "R9 owner keeps before frame");
    cyc(8'h08, 8'hFF, '0, '0, 8'h08, 1'b0, "R9 released when request drops");
    cyc(8'h00, 8'hFF, '0, '0, 8'h00, 1'b0, "R9 idle");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule